// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block owns the row and column strobes and the write enable of an asynchronous DRAM whenever the memory needs attention that is not a data transfer. After a synchronous reset it keeps every strobe inactive for a power-up pause, then runs a burst of wake-up refresh cycles on its own authority, and only then reports the memory as ready for normal traffic.

In normal operation an interval timer posts one refresh obligation per refresh slot into a pending counter. The count is exported to the bus arbiter together with a request and an urgent flag. Each time the arbiter grants the bus while work is pending and the strobe sequencer is idle, one refresh cycle is launched and one obligation is retired. The default refresh style lowers the column strobe before the row strobe, so the memory uses its internal row counter and the address lines carry nothing. A parameter selects a row-strobe-only style instead. In that style an internal row counter is driven out and advances after every cycle.

If the pending counter is full and another slot expires, the refresh deadline is taken as broken. The block drops ready, discards the backlog and repeats the full wake-up burst. The pause, the slot length, the strobe phase lengths, the burst size and the thresholds are all parameters, given in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, `ras_n_o` and `cas_n_o` stay high and `ready_o` stays low for exactly PAUSE_CYC cycles. The first strobe goes low in the next cycle.
- R2: Between the end of the pause and the rise of `ready_o`, exactly WAKE_CNT refresh cycles are issued, whatever the value of `grant_i`.
- R3: In column-first mode (RAS_ONLY=0), `cas_n_o` goes low exactly T_CSR cycles before `ras_n_o` goes low, and both return high together.
- R4: `we_n_o` is high (1) at every falling edge of `ras_n_o`, and it is high at all other times too.
- R5: Each low pulse of `ras_n_o` lasts exactly T_RAS cycles. Between two pulses, `ras_n_o` stays high for at least T_RP cycles.
- R6: While `ready_o` is high, `pending_o` grows by one per INTERVAL_CYC cycles, counted from the rise of `ready_o`, less the refreshes already completed. `req_o` is high exactly when `ready_o` is high and `pending_o` is nonzero.
- R7: `urgent_o` is high exactly when `ready_o` is high and `pending_o` >= URGENT_TH.
- R8: While ready, a refresh cycle starts only after a clock edge at which `grant_i` was 1. Each refresh that completes while ready lowers `pending_o` by one.
- R9: If a slot expires while `pending_o` equals PEND_MAX and no refresh is completing, `ready_o` falls at once. The backlog is cleared, the R2 wake-up burst is repeated, and `pending_o` is 0 when `ready_o` rises again.
- R10: In row-only mode (RAS_ONLY=1), `cas_n_o` never goes low. `row_o` at each falling edge of `ras_n_o` is one more than at the previous one, modulo 2^ROW_W, and the first such value is 0.
- R11: In column-first mode, `row_o` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_i | input | 1 | Arbiter grants the memory bus for one refresh |
| ready_o | output | 1 | Initialisation done, normal accesses allowed |
| req_o | output | 1 | At least one refresh is pending |
| urgent_o | output | 1 | Backlog has reached the urgency threshold |
| busy_o | output | 1 | A refresh cycle is driving the strobes |
| pending_o | output | PEND_W | Number of refresh slots not yet served |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |
| row_o | output | ROW_W | Row address for row-only refresh, 0 otherwise |

## Verification
A grant seen at a clock edge shows up as a strobe change one cycle later. A slot that expires at the INTERVAL_CYC-th ready cycle is visible in `pending_o` from cycle INTERVAL_CYC+1. The first strobe falls at sampling index PAUSE_CYC after reset release. The bench samples on the falling clock edge and compares against closed-form counts: slots elapsed equal (ready cycles - 1) / INTERVAL_CYC. It applies the pending balance only in cycles where `busy_o` is low, because a completing refresh retires its obligation at the same edge at which the sequencer goes idle. Pulse widths and the strobe lead are measured edge to edge in sampled cycles. Expected row values are kept by a bench counter.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_ACT,
        SQ_PRE
    } seq_state_e;

    typedef enum logic [1:0] {
        CT_PAUSE,
        CT_WAKE,
        CT_RUN
    } ctl_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam int DEF_CLK_MHZ   = 200;
    localparam int PAUSE_NS      = 200_000;
    localparam int SLOT_NS       = 15_600;

    function automatic int ns_to_cycles(input int mhz, input int ns);
        return (mhz * ns) / 1000;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dref_interval_timer.sv
module dref_interval_timer #(
    parameter int INTERVAL_CYC = 3120
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= CW'(INTERVAL_CYC - 1);
        end else if (cnt_q == '0) begin
            cnt_q <= CW'(INTERVAL_CYC - 1);
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dref_pending_ctr.sv
module dref_pending_ctr #(
    parameter int PEND_MAX = 8,
    localparam int PEND_W  = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              inc,
    input  logic              dec,
    output logic [PEND_W-1:0] count,
    output logic              overflow
);
    localparam logic [PEND_W-1:0] FULL = PEND_W'(PEND_MAX);

    logic [PEND_W-1:0] cnt_q;

    assign count    = cnt_q;
    assign overflow = inc && !dec && (cnt_q == FULL);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (inc && !dec && cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dref_strobe_seq.sv
module dref_strobe_seq
    import dref_pkg::*;
#(
    parameter bit RAS_ONLY = 1'b0,
    parameter int ROW_W    = 11,
    parameter int T_CSR    = 2,
    parameter int T_RAS    = 10,
    parameter int T_RP     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output strobe_t          strb,
    output logic [ROW_W-1:0] row
);
    localparam int TW = $clog2(max3(T_CSR, T_RAS, T_RP) + 1);

    seq_state_e    st_q;
    logic [TW-1:0] cnt_q;

    assign busy = (st_q != SQ_IDLE);
    assign done = (st_q == SQ_PRE) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: if (start) begin
                    if (RAS_ONLY) begin
                        st_q  <= SQ_ACT;
                        cnt_q <= TW'(T_RAS - 1);
                    end else begin
                        st_q  <= SQ_LEAD;
                        cnt_q <= TW'(T_CSR - 1);
                    end
                end
                SQ_LEAD: if (cnt_q == '0) begin
                    st_q  <= SQ_ACT;
                    cnt_q <= TW'(T_RAS - 1);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                SQ_ACT: if (cnt_q == '0) begin
                    st_q  <= SQ_PRE;
                    cnt_q <= TW'(T_RP - 1);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                SQ_PRE: if (cnt_q == '0) begin
                    st_q <= SQ_IDLE;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        strb.ras_n = (st_q != SQ_ACT);
        strb.we_n  = 1'b1;
        if (RAS_ONLY) begin
            strb.cas_n = 1'b1;
        end else begin
            strb.cas_n = !((st_q == SQ_LEAD) || (st_q == SQ_ACT));
        end
    end

    generate
        if (RAS_ONLY) begin : g_row_ctr
            logic [ROW_W-1:0] row_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    row_q <= '0;
                end else if (done) begin
                    row_q <= row_q + 1'b1;
                end
            end
            assign row = row_q;
        end else begin : g_no_row
            assign row = '0;
        end
    endgenerate
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dref_pkg::*;
#(
    parameter int  CLK_MHZ      = DEF_CLK_MHZ,
    parameter int  PAUSE_CYC    = ns_to_cycles(CLK_MHZ, PAUSE_NS),
    parameter int  INTERVAL_CYC = ns_to_cycles(CLK_MHZ, SLOT_NS),
    parameter int  WAKE_CNT     = 8,
    parameter int  T_CSR        = 2,
    parameter int  T_RAS        = 10,
    parameter int  T_RP         = 6,
    parameter int  PEND_MAX     = 8,
    parameter int  URGENT_TH    = 4,
    parameter bit  RAS_ONLY     = 1'b0,
    parameter int  ROW_W        = 11,
    localparam int PEND_W       = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grant_i,
    output logic              ready_o,
    output logic              req_o,
    output logic              urgent_o,
    output logic              busy_o,
    output logic [PEND_W-1:0] pending_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ROW_W-1:0]  row_o
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int WW = $clog2(WAKE_CNT + 1);

    ctl_state_e        ctl_q;
    logic [PW-1:0]     pause_q;
    logic [WW-1:0]     wake_left_q;
    logic              tick, overflow, consume;
    logic              seq_start, seq_busy, seq_done;
    logic [PEND_W-1:0] pend;
    strobe_t           strb;
    logic              running;

    assign running = (ctl_q == CT_RUN);
    assign consume = seq_done && running;

    always_comb begin
        seq_start = 1'b0;
        if (!seq_busy) begin
            if (ctl_q == CT_WAKE) begin
                seq_start = (wake_left_q != '0);
            end else if (running) begin
                seq_start = grant_i && (pend != '0) && !overflow;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q       <= CT_PAUSE;
            pause_q     <= PW'(PAUSE_CYC - 1);
            wake_left_q <= WW'(WAKE_CNT);
        end else begin
            unique case (ctl_q)
                CT_PAUSE: begin
                    if (pause_q == '0) ctl_q <= CT_WAKE;
                    else               pause_q <= pause_q - 1'b1;
                end
                CT_WAKE: begin
                    if (seq_start) wake_left_q <= wake_left_q - 1'b1;
                    if (wake_left_q == '0 && !seq_busy) ctl_q <= CT_RUN;
                end
                CT_RUN: begin
                    if (overflow) begin
                        ctl_q       <= CT_WAKE;
                        wake_left_q <= WW'(WAKE_CNT);
                    end
                end
                default: ctl_q <= CT_PAUSE;
            endcase
        end
    end

    dref_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (running),
        .tick (tick)
    );

    dref_pending_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .clear    (!running),
        .inc      (tick),
        .dec      (consume),
        .count    (pend),
        .overflow (overflow)
    );

    dref_strobe_seq #(
        .RAS_ONLY (RAS_ONLY),
        .ROW_W    (ROW_W),
        .T_CSR    (T_CSR),
        .T_RAS    (T_RAS),
        .T_RP     (T_RP)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (seq_start),
        .busy  (seq_busy),
        .done  (seq_done),
        .strb  (strb),
        .row   (row_o)
    );

    assign ready_o   = running;
    assign req_o     = running && (pend != '0);
    assign urgent_o  = running && (int'(pend) >= URGENT_TH);
    assign busy_o    = seq_busy;
    assign pending_o = pend;
    assign ras_n_o   = strb.ras_n;
    assign cas_n_o   = strb.cas_n;
    assign we_n_o    = strb.we_n;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
    parameter bit RAS_ONLY = 1'b0,
    parameter int T_RAS    = 10,
    parameter int PEND_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              grant_i,
    input logic              ready_o,
    input logic              busy_o,
    input logic [PEND_W-1:0] pending_o,
    input logic              ras_n_o,
    input logic              cas_n_o
);
    localparam int LW = $clog2(T_RAS + 2);

    logic [LW-1:0] low_len_q;

    always_ff @(posedge clk) begin
        if (rst || ras_n_o) low_len_q <= '0;
        else if (int'(low_len_q) <= T_RAS) low_len_q <= low_len_q + 1'b1;
    end

    // R5: the row strobe pulse has exactly the programmed width
    p_ras_width_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n_o) |-> (int'($past(low_len_q)) == T_RAS - 1));

    // R6: the backlog moves by at most one per cycle while ready
    p_pend_step_r6: assert property (@(posedge clk) disable iff (rst)
        (ready_o && $past(ready_o)) |->
        ((int'(pending_o) - int'($past(pending_o))) inside {-1, 0, 1}));

    // R8: a refresh launched while ready follows a grant
    p_grant_start_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy_o) && $past(ready_o)) |-> $past(grant_i));

    // R9: a completed wake-up burst leaves no backlog
    p_wake_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> (pending_o == '0));

    generate
        if (RAS_ONLY) begin : g_ro
            // R10: column strobe idle in row-only mode
            p_cas_idle_r10: assert property (@(posedge clk) disable iff (rst)
                busy_o |-> cas_n_o);
        end else begin : g_cbr
            // R3: column strobe leads the row strobe
            p_cas_lead_r3: assert property (@(posedge clk) disable iff (rst)
                $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));
        end
    endgenerate
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
    .RAS_ONLY (RAS_ONLY),
    .T_RAS    (T_RAS),
    .PEND_W   (PEND_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .grant_i   (grant_i),
    .ready_o   (ready_o),
    .busy_o    (busy_o),
    .pending_o (pending_o),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o)
);

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
    localparam int PAUSE    = 50;
    localparam int INTV     = 40;
    localparam int WAKE     = 8;
    localparam int TCSR     = 2;
    localparam int TRAS     = 4;
    localparam int TRP      = 3;
    localparam int PMAX     = 6;
    localparam int UTH      = 3;
    localparam int RW_RO    = 4;
    localparam int PW       = $clog2(PMAX + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic grant = 1'b0;
    always #2.5 clk = ~clk;

    logic          ready, req, urgent, busy, ras_n, cas_n, we_n;
    logic [PW-1:0] pend;
    logic [10:0]   row;
    logic          r_ready, r_req, r_urgent, r_busy, r_ras_n, r_cas_n, r_we_n;
    logic [PW-1:0] r_pend;
    logic [RW_RO-1:0] r_row;

    dram_refresh_sched #(
        .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .WAKE_CNT(WAKE), .T_CSR(TCSR),
        .T_RAS(TRAS), .T_RP(TRP), .PEND_MAX(PMAX), .URGENT_TH(UTH),
        .RAS_ONLY(1'b0), .ROW_W(11)
    ) i_dram_refresh_sched (
        .clk(clk), .rst(rst), .grant_i(grant), .ready_o(ready), .req_o(req),
        .urgent_o(urgent), .busy_o(busy), .pending_o(pend), .ras_n_o(ras_n),
        .cas_n_o(cas_n), .we_n_o(we_n), .row_o(row)
    );

    dram_refresh_sched #(
        .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .WAKE_CNT(WAKE), .T_CSR(TCSR),
        .T_RAS(TRAS), .T_RP(TRP), .PEND_MAX(PMAX), .URGENT_TH(UTH),
        .RAS_ONLY(1'b1), .ROW_W(RW_RO)
    ) i_dram_refresh_sched_ro (
        .clk(clk), .rst(rst), .grant_i(1'b1), .ready_o(r_ready), .req_o(r_req),
        .urgent_o(r_urgent), .busy_o(r_busy), .pending_o(r_pend), .ras_n_o(r_ras_n),
        .cas_n_o(r_cas_n), .we_n_o(r_we_n), .row_o(r_row)
    );

    int tests = 0;
    int fails = 0;
    bit done_flag = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int slots_elapsed(input int n);
        return (n >= 1) ? (n - 1) / INTV : 0;
    endfunction

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // sampling helpers written at posedge
    logic seen_edge = 1'b0;
    logic grant_q   = 1'b0;
    always @(posedge clk) begin
        if (!rst) seen_edge <= 1'b1;
        grant_q <= grant;
    end

    // CBR instance monitor state
    int idx = 0, first_act = -1, r_first_act = -1;
    int csr_len = 0, low_len = 0, high_len = 1000;
    int wake_pulses = 0, run_pulses = 0, ready_n = 0, rewakes = 0;
    logic p_ras = 1'b1, p_ready = 1'b0, p_busy = 1'b0;
    int p_pend = 0;
    // RAS-only instance monitor state
    logic [RW_RO-1:0] exp_row = '0;
    int r_pulses = 0, r_low_len = 0;
    logic rp_ras = 1'b1;

    always @(negedge clk) begin
        if (seen_edge && !done_flag) begin
            if (first_act < 0 && (!ras_n || !cas_n)) first_act = idx;
            if (r_first_act < 0 && (!r_ras_n || !r_cas_n)) r_first_act = idx;
            if (idx < PAUSE)
                chk(ready == 1'b0 && r_ready == 1'b0, "R1 ready low in pause", int'(ready), 0);
            idx++;

            // ---- column-first instance ----
            if (!ras_n && p_ras) begin
                chk(csr_len == TCSR, "R3 cas lead", csr_len, TCSR);
                chk(we_n == 1'b1, "R4 we high at ras fall", int'(we_n), 1);
                chk(high_len >= TRP, "R5 ras precharge", high_len, TRP);
                chk(row == '0, "R11 row held zero", int'(row), 0);
                high_len = 0;
                if (ready) run_pulses++; else wake_pulses++;
            end
            if (ras_n && !p_ras) begin
                chk(low_len == TRAS, "R5 ras width", low_len, TRAS);
                chk(cas_n == 1'b1, "R3 cas rises with ras", int'(cas_n), 1);
                low_len = 0;
            end
            if (!ras_n) low_len++; else high_len++;
            if (ras_n && !cas_n) csr_len++;
            else if (cas_n) csr_len = 0;

            if (ready && !p_ready) begin
                chk(wake_pulses == WAKE, "R2 wake burst size", wake_pulses, WAKE);
                chk(pend == '0, "R9 backlog cleared", int'(pend), 0);
                ready_n = 1;
                run_pulses = 0;
            end else if (ready) begin
                ready_n++;
            end
            if (!ready && p_ready) begin
                chk(p_pend == PMAX, "R9 drop only when full", p_pend, PMAX);
                wake_pulses = 0;
                rewakes++;
            end
            if (ready && !busy) begin
                chk(int'(pend) == slots_elapsed(ready_n) - run_pulses, "R6 R8 pending balance",
                    int'(pend), slots_elapsed(ready_n) - run_pulses);
            end
            chk(req == (ready && pend != '0), "R6 req", int'(req), int'(ready && pend != '0));
            chk(urgent == (ready && int'(pend) >= UTH), "R7 urgent",
                int'(urgent), int'(ready && int'(pend) >= UTH));
            if (busy && !p_busy && ready && p_ready)
                chk(grant_q == 1'b1, "R8 start needs grant", int'(grant_q), 1);
            p_ras = ras_n; p_ready = ready; p_busy = busy; p_pend = int'(pend);

            // ---- row-only instance ----
            if (!r_cas_n) chk(1'b0, "R10 cas stays high", 0, 1);
            if (!r_ras_n && rp_ras) begin
                chk(r_row == exp_row, "R10 row sequence", int'(r_row), int'(exp_row));
                chk(r_we_n == 1'b1, "R4 we high row-only", int'(r_we_n), 1);
                r_pulses++;
            end
            if (r_ras_n && !rp_ras) begin
                chk(r_low_len == TRAS, "R5 ras width row-only", r_low_len, TRAS);
                r_low_len = 0;
                exp_row = exp_row + 1'b1;
            end
            if (!r_ras_n) r_low_len++;
            rp_ras = r_ras_n;
        end
    end

    task automatic wait_ready(input int limit);
        for (int i = 0; i < limit && !ready; i++) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(ready == 1'b0 && req == 1'b0 && urgent == 1'b0, "R1 reset outputs", int'(ready), 0);
        chk(ras_n && cas_n && we_n, "R1 reset strobes", int'({ras_n, cas_n, we_n}), 7);
        chk(pend == '0, "R1 reset pending", int'(pend), 0);
        rst = 1'b0;

        wait_ready(2000);
        chk(ready == 1'b1, "R2 ready after wake", int'(ready), 1);
        chk(first_act == PAUSE, "R1 first strobe index", first_act, PAUSE);
        chk(r_first_act == PAUSE, "R1 first strobe row-only", r_first_act, PAUSE);

        // random grants
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            grant = (($urandom % 10) < 7);
        end
        // directed: backlog builds to the urgent level, then drains
        @(negedge clk); grant = 1'b0;
        repeat (5 * INTV) @(negedge clk);
        chk(urgent == 1'b1, "R7 urgent after backlog", int'(urgent), 1);
        grant = 1'b1;
        repeat (3 * INTV) @(negedge clk);
        chk(int'(pend) <= 1, "R8 drained", int'(pend), 0);

        // directed: starve until overflow forces a new wake-up burst
        grant = 1'b0;
        for (int i = 0; i < (PMAX + 3) * INTV && ready; i++) @(negedge clk);
        chk(ready == 1'b0, "R9 ready drop on overflow", int'(ready), 0);
        wait_ready(1000);
        chk(rewakes == 1, "R9 one rewake", rewakes, 1);
        grant = 1'b1;
        repeat (4 * INTV) @(negedge clk);

        chk(r_pulses > (1 << RW_RO), "R10 row wrapped", r_pulses, (1 << RW_RO) + 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule